// File: doc/BRIEF.md
# Dual-User Protected Memory Bus Steering Controller

This block sits between two 16-bit user ports, one protected memory port (16 data bits plus an 8-bit check byte) and a small transfer register. It contains a flow-through error-correcting code core. A master-select input names the user port whose read/write, memory-select and enable inputs drive the transaction. A path-select input chooses between the protected memory and the user-to-user transfer register. Every bidirectional bus is modelled as three signals: an input, an output and an output enable. The block drives each output enable and feeds each output from the right source.

On a memory write, the master's data and the freshly generated check byte are presented to memory. On a memory read, the data word is checked. A single flipped data bit is inverted back when correction is enabled; in detect mode the raw word is passed through. The word is placed on both user outputs, so the non-master port can listen, but only the master's output enable can assert. A diagnostic select replaces the returned word with the syndrome and the received check byte. In transfer mode, the master writes the register on a clock edge, and any master can later read it back. This lets data cross from one user to the other.

Top module: `edac_bus_steer`

## Requirements
- R1: With `path_mem`=1 the transaction targets memory. With `path_mem`=0 it targets the transfer register, and `mem_data_oe` stays 0 for any control pattern.
- R2: `master_sel`=0 makes port A master and `master_sel`=1 makes port B master. The non-master's `*_rw`, `*_mem_n` and `*_en_n` inputs have no effect on any output, and the non-master's output enable stays 0.
- R3: Memory select and enable are active low, and `*_rw`=1 means read. The master's output enable is 1 only when its memory select is 0, its enable is 0 and `*_rw`=1. With memory select high, no output enable is asserted.
- R4: On a memory write (`path_mem`=1, master select 0, rw 0), `mem_data_oe`=1, `mem_data_o` equals the master's data, and `mem_chk_o` holds the check byte. Data bit i has column c(i): the i-th 8-bit value, in ascending numeric order, that has exactly three bits set. Check bit j is the XOR of the data bits i whose c(i) has bit j set.
- R5: On a memory read with `correct_en`=1, syndrome = `mem_chk_i` XOR check(`mem_data_i`). A syndrome equal to c(i) inverts data bit i and raises `err_corr_o`=1 with `err_uncorr_o`=0.
- R6: With `correct_en`=0, the read word is the raw `mem_data_i`, while the error flags are still produced as in R5 and R7.
- R7: A syndrome with exactly one bit set is a check-bit error: `err_corr_o`=1 and the data is unchanged. Any other nonzero syndrome that matches no column gives `err_uncorr_o`=1 and `err_corr_o`=0. A zero syndrome gives neither flag.
- R8: During a memory read, `a_data_o` and `b_data_o` both carry the read word, so the non-master can observe the transaction.
- R9: A transfer write (`path_mem`=0, master select 0, rw 0) loads the master's data into the transfer register at the clock edge. The register holds its value until the next transfer write. A transfer read presents the register on the outputs.
- R10: With `diag_n`=0 during a memory read, the read word is {syndrome[7:0], `mem_chk_i`[7:0]}, with the syndrome in the upper byte.
- R11: Reset (`rst_n`=0) clears the transfer register to zero.
- R12: At most one driver is enabled on any bus. `mem_data_oe` never coincides with a user output enable, and `a_data_oe` and `b_data_oe` are never both 1.
- R13: Both error flags are 0 in every cycle that is not a memory read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the transfer register |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_sel | input | 1 | 0: port A controls, 1: port B controls |
| path_mem | input | 1 | 1: memory access, 0: transfer register |
| correct_en | input | 1 | 1: correct single data-bit errors, 0: detect only |
| diag_n | input | 1 | Active low: return syndrome and check byte on reads |
| a_rw | input | 1 | Port A read (1) / write (0) |
| a_mem_n | input | 1 | Port A select, active low |
| a_en_n | input | 1 | Port A output enable request, active low |
| a_data_i | input | 16 | Port A bus, incoming |
| a_data_o | output | 16 | Port A bus, outgoing |
| a_data_oe | output | 1 | Port A bus drive enable |
| b_rw | input | 1 | Port B read (1) / write (0) |
| b_mem_n | input | 1 | Port B select, active low |
| b_en_n | input | 1 | Port B output enable request, active low |
| b_data_i | input | 16 | Port B bus, incoming |
| b_data_o | output | 16 | Port B bus, outgoing |
| b_data_oe | output | 1 | Port B bus drive enable |
| mem_data_i | input | 16 | Memory data bus, incoming |
| mem_data_o | output | 16 | Memory data bus, outgoing |
| mem_data_oe | output | 1 | Memory data and check bus drive enable |
| mem_chk_i | input | 8 | Memory check byte, incoming |
| mem_chk_o | output | 8 | Generated check byte, outgoing |
| err_corr_o | output | 1 | Correctable error seen on this read |
| err_uncorr_o | output | 1 | Uncorrectable error seen on this read |

## Verification
In one cycle, a memory read delivers a corrected word to the master, and the non-master listens to that same word while its own control inputs request a conflicting write. The bench builds this case in every table row by driving the non-master with select low, write and enable low. It runs every row under both master settings. A row passes when both user outputs equal the expected word and the flags match the row. Only the master's enable may be set and the memory enable must stay low, which shows that the ignored controls changed nothing.

// File: rtl/edac_steer_pkg.sv
package edac_steer_pkg;
  localparam int CHK_W     = 8;
  localparam int MAX_DATA_W = 56;  // weight-3 bytes available as columns

  typedef enum logic [2:0] {
    OP_IDLE, OP_MEM_WR, OP_MEM_RD, OP_BUF_WR, OP_BUF_RD
  } steer_op_e;

  function automatic int pop8(input logic [7:0] v);
    int n;
    n = 0;
    for (int k = 0; k < 8; k++) n += int'(v[k]);
    return n;
  endfunction

  // idx-th byte value (ascending) having exactly three ones
  function automatic logic [CHK_W-1:0] code_column(input int idx);
    int n;
    logic [CHK_W-1:0] r;
    n = 0;
    r = '0;
    for (int v = 0; v < 256; v++) begin
      if (pop8(8'(v)) == 3) begin
        if (n == idx) r = 8'(v);
        n++;
      end
    end
    return r;
  endfunction

  // data bits that feed check bit j
  function automatic logic [MAX_DATA_W-1:0] row_mask(input int j);
    logic [MAX_DATA_W-1:0] m;
    logic [CHK_W-1:0] c;
    for (int i = 0; i < MAX_DATA_W; i++) begin
      c = code_column(i);
      m[i] = c[j];
    end
    return m;
  endfunction
endpackage

// File: rtl/edac_code_core.sv
module edac_code_core
  import edac_steer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [CHK_W-1:0]  rd_chk,
  input  logic              correct_en,
  output logic [CHK_W-1:0]  gen_chk,
  output logic [CHK_W-1:0]  syndrome,
  output logic [DATA_W-1:0] fixed_data,
  output logic              err_corr,
  output logic              err_uncorr
);
  logic [CHK_W-1:0]  rd_gen;
  logic [DATA_W-1:0] hit;
  logic              chk_only;

  for (genvar j = 0; j < CHK_W; j++) begin : g_row
    localparam logic [MAX_DATA_W-1:0] MFULL = row_mask(j);
    assign gen_chk[j] = ^(wr_data & MFULL[DATA_W-1:0]);
    assign rd_gen[j]  = ^(rd_data & MFULL[DATA_W-1:0]);
  end

  assign syndrome = rd_chk ^ rd_gen;

  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [CHK_W-1:0] COL = code_column(i);
    assign hit[i] = (syndrome == COL);
  end

  assign chk_only   = ($countones(syndrome) == 1);
  assign fixed_data = correct_en ? (rd_data ^ hit) : rd_data;
  assign err_corr   = (|hit) | chk_only;
  assign err_uncorr = (syndrome != '0) & ~err_corr;
endmodule

// File: rtl/edac_port_ctrl.sv
module edac_port_ctrl
  import edac_steer_pkg::*;
(
  input  logic      master_sel,
  input  logic      path_mem,
  input  logic      a_rw,
  input  logic      a_mem_n,
  input  logic      a_en_n,
  input  logic      b_rw,
  input  logic      b_mem_n,
  input  logic      b_en_n,
  output steer_op_e op,
  output logic      a_oe,
  output logic      b_oe,
  output logic      mem_oe
);
  logic m_rw, m_mem_n, m_en_n, rd_drive;

  assign m_rw    = master_sel ? b_rw    : a_rw;
  assign m_mem_n = master_sel ? b_mem_n : a_mem_n;
  assign m_en_n  = master_sel ? b_en_n  : a_en_n;

  always_comb begin
    if (m_mem_n)       op = OP_IDLE;
    else if (path_mem) op = m_rw ? OP_MEM_RD : OP_MEM_WR;
    else               op = m_rw ? OP_BUF_RD : OP_BUF_WR;
  end

  assign rd_drive = ((op == OP_MEM_RD) || (op == OP_BUF_RD)) && !m_en_n;
  assign a_oe     = rd_drive && !master_sel;
  assign b_oe     = rd_drive && master_sel;
  assign mem_oe   = (op == OP_MEM_WR);
endmodule

// File: rtl/edac_xfer_buf.sv
module edac_xfer_buf #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

  assert_buf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
  assert_buf_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(din)));
endmodule

// File: rtl/edac_bus_steer.sv
module edac_bus_steer
  import edac_steer_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_sel,
  input  logic              path_mem,
  input  logic              correct_en,
  input  logic              diag_n,
  input  logic              a_rw,
  input  logic              a_mem_n,
  input  logic              a_en_n,
  input  logic [DATA_W-1:0] a_data_i,
  output logic [DATA_W-1:0] a_data_o,
  output logic              a_data_oe,
  input  logic              b_rw,
  input  logic              b_mem_n,
  input  logic              b_en_n,
  input  logic [DATA_W-1:0] b_data_i,
  output logic [DATA_W-1:0] b_data_o,
  output logic              b_data_oe,
  input  logic [DATA_W-1:0] mem_data_i,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              mem_data_oe,
  input  logic [CHK_W-1:0]  mem_chk_i,
  output logic [CHK_W-1:0]  mem_chk_o,
  output logic              err_corr_o,
  output logic              err_uncorr_o
);
  steer_op_e         op;
  logic [DATA_W-1:0] wr_src, fixed, buf_q, rd_word, diag_word;
  logic [CHK_W-1:0]  syndrome;
  logic              core_corr, core_uncorr;

  edac_port_ctrl u_ctrl (
    .master_sel(master_sel), .path_mem(path_mem),
    .a_rw(a_rw), .a_mem_n(a_mem_n), .a_en_n(a_en_n),
    .b_rw(b_rw), .b_mem_n(b_mem_n), .b_en_n(b_en_n),
    .op(op), .a_oe(a_data_oe), .b_oe(b_data_oe), .mem_oe(mem_data_oe)
  );

  assign wr_src = master_sel ? b_data_i : a_data_i;

  edac_code_core #(.DATA_W(DATA_W)) u_core (
    .wr_data(wr_src), .rd_data(mem_data_i), .rd_chk(mem_chk_i),
    .correct_en(correct_en), .gen_chk(mem_chk_o), .syndrome(syndrome),
    .fixed_data(fixed), .err_corr(core_corr), .err_uncorr(core_uncorr)
  );

  edac_xfer_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(op == OP_BUF_WR),
    .din(wr_src), .q(buf_q)
  );

  assign diag_word = DATA_W'({syndrome, mem_chk_i});

  always_comb begin
    if (op == OP_BUF_RD) rd_word = buf_q;
    else if (!diag_n)    rd_word = diag_word;
    else                 rd_word = fixed;
  end

  assign a_data_o     = rd_word;
  assign b_data_o     = rd_word;
  assign mem_data_o   = wr_src;
  assign err_corr_o   = (op == OP_MEM_RD) && core_corr;
  assign err_uncorr_o = (op == OP_MEM_RD) && core_uncorr;

  assert_one_driver_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_data_oe && (a_data_oe || b_data_oe)) && !(a_data_oe && b_data_oe));
  assert_mem_oe_path_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_data_oe |-> path_mem);
  assert_listener_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    master_sel |-> !a_data_oe);
  assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_corr_o && err_uncorr_o));
  assert_flags_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !path_mem |-> (!err_corr_o && !err_uncorr_o));
endmodule

// File: tb/edac_bus_steer_tb_top.sv
module edac_bus_steer_tb_top;
  logic clk = 0, rst_n = 0;
  logic master_sel = 0, path_mem = 1, correct_en = 1, diag_n = 1;
  logic a_rw = 1, a_mem_n = 1, a_en_n = 1, b_rw = 1, b_mem_n = 1, b_en_n = 1;
  logic [15:0] a_data_i = 0, b_data_i = 0, mem_data_i = 0;
  logic [7:0]  mem_chk_i = 0;
  logic [15:0] a_data_o, b_data_o, mem_data_o;
  logic a_data_oe, b_data_oe, mem_data_oe, err_corr_o, err_uncorr_o;
  logic [7:0] mem_chk_o;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  edac_bus_steer dut_i (.*);

  // row: data, data flips, check flips, correct_en, exp corr, exp uncorr
  localparam logic [42:0] VEC [8] = '{
    {16'hA5C3, 16'h0000, 8'h00, 3'b100},
    {16'hA5C3, 16'h0001, 8'h00, 3'b110},
    {16'h1234, 16'h8000, 8'h00, 3'b110},
    {16'h1234, 16'h0080, 8'h00, 3'b010},
    {16'hFFFF, 16'h0000, 8'h08, 3'b110},
    {16'h0000, 16'h0204, 8'h00, 3'b101},
    {16'h5A5A, 16'h0020, 8'h01, 3'b101},
    {16'h0F0F, 16'h0000, 8'h00, 3'b000}
  };

  function automatic logic [7:0] colv(input int idx);
    int n = 0;
    logic [7:0] r = 0;
    for (int v = 0; v < 256; v++) begin
      int w = 0;
      for (int k = 0; k < 8; k++) w += (v >> k) & 1;
      if (w == 3) begin
        if (n == idx) r = 8'(v);
        n++;
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] chk_of(input logic [15:0] d);
    logic [7:0] c = 0;
    for (int i = 0; i < 16; i++) if (d[i]) c ^= colv(i);
    return c;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // master control, other port gets a conflicting command
  task automatic drive(input logic m, input logic path, input logic rw,
                       input logic sel_n, input logic en_n);
    master_sel = m; path_mem = path;
    if (!m) begin
      a_rw = rw; a_mem_n = sel_n; a_en_n = en_n; b_rw = ~rw; b_mem_n = 0; b_en_n = 0;
    end else begin
      b_rw = rw; b_mem_n = sel_n; b_en_n = en_n; a_rw = ~rw; a_mem_n = 0; a_en_n = 0;
    end
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11: reset value visible through a transfer read
    @(negedge clk); drive(0, 0, 1, 0, 0); #2;
    chk("R11 reset buffer", a_data_o, 16'h0000);
    chk("R3 read oe master A", {15'd0, a_data_oe}, 16'd1);

    for (int m = 0; m < 2; m++) begin
      for (int r = 0; r < 8; r++) begin
        logic [15:0] d, df, expw; logic [7:0] cf; logic ce, ec, eu;
        {d, df, cf, ce, ec, eu} = VEC[r];
        // R4 memory write
        @(negedge clk); drive(m[0], 1, 0, 0, 0);
        if (m == 0) a_data_i = d; else b_data_i = d;
        if (m == 0) b_data_i = ~d; else a_data_i = ~d;
        #2;
        chk("R4 write data", mem_data_o, d);
        chk("R4 write check", {8'd0, mem_chk_o}, {8'd0, chk_of(d)});
        chk("R4 R12 write oes", {13'd0, mem_data_oe, a_data_oe, b_data_oe}, 16'b100);
        chk("R13 flags on write", {14'd0, err_corr_o, err_uncorr_o}, 16'd0);
        // R5 R6 R7 R8 R2 memory read
        @(negedge clk); drive(m[0], 1, 1, 0, 0);
        correct_en = ce; mem_data_i = d ^ df; mem_chk_i = chk_of(d) ^ cf; #2;
        expw = (ce && ec) ? d : (d ^ df);
        chk("R5 R6 master word", m ? b_data_o : a_data_o, expw);
        chk("R8 listener word", m ? a_data_o : b_data_o, expw);
        chk("R7 flags", {14'd0, err_corr_o, err_uncorr_o}, {14'd0, ec, eu});
        chk("R2 R12 read oes", {13'd0, mem_data_oe, a_data_oe, b_data_oe},
            m ? 16'b001 : 16'b010);
      end
    end
    correct_en = 1;

    // R3: enable high or select high blocks output
    @(negedge clk); drive(0, 1, 1, 0, 1); #2;
    chk("R3 en_n high no oe", {14'd0, a_data_oe, b_data_oe}, 16'd0);
    @(negedge clk); drive(1, 1, 1, 1, 0); mem_data_i = 16'h0001; mem_chk_i = 0; #2;
    chk("R3 sel high no oe", {13'd0, mem_data_oe, a_data_oe, b_data_oe}, 16'd0);
    chk("R13 flags idle", {14'd0, err_corr_o, err_uncorr_o}, 16'd0);

    // R10 diagnostic word
    @(negedge clk); drive(0, 1, 1, 0, 0); diag_n = 0;
    mem_data_i = 16'h4321 ^ 16'h0004; mem_chk_i = chk_of(16'h4321); #2;
    chk("R10 diag word", a_data_o, {colv(2), chk_of(16'h4321)});
    diag_n = 1;

    // R9 R1: A writes buffer, B reads it
    @(negedge clk); drive(0, 0, 0, 0, 0); a_data_i = 16'hBEEF; b_data_i = 16'h1111; #2;
    chk("R1 no mem oe on xfer write", {15'd0, mem_data_oe}, 16'd0);
    @(negedge clk); drive(1, 0, 1, 0, 0); a_data_i = 16'h2222; #2;
    chk("R9 B reads A data", b_data_o, 16'hBEEF);
    chk("R2 R12 xfer read oes", {13'd0, mem_data_oe, a_data_oe, b_data_oe}, 16'b001);
    @(negedge clk); drive(0, 1, 1, 1, 1); repeat (2) @(negedge clk);
    drive(1, 0, 1, 0, 0); #2;
    chk("R9 buffer holds", b_data_o, 16'hBEEF);
    // B writes, A reads
    @(negedge clk); drive(1, 0, 0, 0, 0); b_data_i = 16'h1357; #2;
    chk("R13 flags on xfer", {14'd0, err_corr_o, err_uncorr_o}, 16'd0);
    @(negedge clk); drive(0, 0, 1, 0, 0); #2;
    chk("R9 A reads B data", a_data_o, 16'h1357);

    // R11 reset mid-run
    @(negedge clk); rst_n = 0; #2; rst_n = 1; #1;
    chk("R11 reset clears", a_data_o, 16'h0000);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule